// File: doc/BRIEF.md
# Overlay Key and Blend Factor Generator

This block sits in a video output pipeline, one pixel per clock, in front of a two-input blender. For every pixel it produces two things: an overlay control bit and an 8-bit blend coefficient. The overlay bit comes from one of three places. It can be a masked compare of the low pixel byte, a full-colour compare of 8, 15 or 24 pixel bits against a programmed key, or a fixed bit of the stored 32-bit word. A control input can complement the bit.

The blend coefficient has two modes. In bilevel mode the overlay bit picks one of two programmed constants. In dynamic mode the coefficient is taken from a live mix input: a zero offset is subtracted, the difference is shifted left by a small gain, and the result is clamped to 0..255. A second invert control complements the coefficient in both modes. All control inputs are quasi-static register values that the surrounding logic provides. The results come out registered one cycle after the pixel, together with a valid flag.

Top module: `ovl_blend_gen`

## Requirements
- R1: While rst_ni is low, valid_o, ovl_o and blend_o are all 0.
- R2: valid_o equals pix_valid_i of the previous clock. ovl_o and blend_o update one clock after a cycle with pix_valid_i=1 and hold their value after a cycle with pix_valid_i=0.
- R3: With cmp_en_i=1 and ovl_src_i=0, the raw overlay bit is 1 when (pix_data_i[7:0] & m) == (cmp_value_i[7:0] & m), where m = cmp_value_i[23:16]. cmp_value_i[15:8] has no effect here.
- R4: With cmp_en_i=1 and ovl_src_i=2, the raw overlay bit is an equality compare whose width depends on pix_fmt_i. For pix_fmt_i=0 (8-bit) it compares bits [7:0]. For pix_fmt_i=1 (16-bit) it compares bits [14:0]. For pix_fmt_i=2 (24-bit) and 3 (32-bit) it compares bits [23:0]. Key bits outside the compared width have no effect.
- R5: With cmp_en_i=0, the raw overlay bit is pix_data_i[15] when ovl_src_i=0, pix_data_i[31] when ovl_src_i=1, and 0 when ovl_src_i is 2 or 3. With cmp_en_i=1, ovl_src_i values 1 and 3 give 0.
- R6: ovl_o is the raw overlay bit XOR ovl_inv_i.
- R7: With blend_mode_i=0 (bilevel), the uninverted coefficient is lvl_on_i when ovl_o=1 and lvl_off_i when ovl_o=0.
- R8: With blend_mode_i=1 (dynamic), the uninverted coefficient is (live_mix_i - mix_zero_i) << g. Here g = mix_gain_i, except that mix_gain_i=3 acts as g=2.
- R9: In dynamic mode, a negative difference gives 0, and a shifted value above 255 gives 255.
- R10: blend_o is the uninverted coefficient XOR {8{mix_inv_i}}, in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_valid_i | input | 1 | Pixel on pix_data_i and live_mix_i is valid |
| pix_data_i | input | 32 | Stored pixel word |
| live_mix_i | input | 8 | Live mix amplitude for dynamic mode |
| cmp_en_i | input | 1 | 1: overlay from compares, 0: from fixed pixel bits |
| ovl_src_i | input | 2 | Overlay source select |
| pix_fmt_i | input | 2 | Pixel format: 0 8-bit, 1 16-bit, 2 24-bit, 3 32-bit |
| cmp_value_i | input | 24 | Compare key; top byte doubles as 8-bit mask |
| ovl_inv_i | input | 1 | Complement the overlay bit |
| blend_mode_i | input | 1 | 0 bilevel, 1 dynamic |
| lvl_on_i | input | 8 | Bilevel constant when overlay is 1 |
| lvl_off_i | input | 8 | Bilevel constant when overlay is 0 |
| mix_zero_i | input | 8 | Dynamic-mode zero offset |
| mix_gain_i | input | 2 | Dynamic-mode left shift |
| mix_inv_i | input | 1 | Complement the coefficient |
| valid_o | output | 1 | Outputs belong to a valid pixel |
| ovl_o | output | 1 | Overlay control bit |
| blend_o | output | 8 | Blend coefficient |

## Verification
The only state in the block is the output register stage, so any fault shows up on the pixel that follows, exactly one clock after the stimulus. A stale or miscaptured register shows as a value that does not change when it should, or that changes after a cycle without a valid pixel. A wrong compare width, wrong mask or wrong clamp shows as a wrong ovl_o or blend_o on the first pixel that reaches that corner. For this reason the directed cases put pixels exactly on the key-width boundaries, on a difference of zero and on the saturation edge.

// File: rtl/ovl_blend_pkg.sv
package ovl_blend_pkg;
  typedef enum logic [1:0] {
    FMT_8  = 2'd0,
    FMT_16 = 2'd1,
    FMT_24 = 2'd2,
    FMT_32 = 2'd3
  } pix_fmt_e;

  localparam logic [1:0] SRC_MASKED_OR_B15 = 2'd0;
  localparam logic [1:0] SRC_TOP_BIT       = 2'd1;
  localparam logic [1:0] SRC_WIDE_OR_ZERO  = 2'd2;
endpackage

// File: rtl/ovl_key_sel.sv
module ovl_key_sel
  import ovl_blend_pkg::*;
#(
  parameter int PIX_W = 32,
  parameter int CMP_W = 24
) (
  input  logic [PIX_W-1:0] pix_i,
  input  logic             cmp_en_i,
  input  logic [1:0]       src_i,
  input  logic [1:0]       fmt_i,
  input  logic [CMP_W-1:0] cmp_i,
  input  logic             inv_i,
  output logic             ovl_o
);
  localparam int BYTE_W = 8;
  localparam int HI_W   = 15;
  localparam int MID_B  = HI_W;

  logic [BYTE_W-1:0] mask;
  logic              masked_hit;
  logic              wide_hit;
  logic              raw;
  logic              unused_pix;

  assign unused_pix = ^pix_i[PIX_W-2:CMP_W];
  assign mask       = cmp_i[CMP_W-1 -: BYTE_W];
  assign masked_hit = ((pix_i[BYTE_W-1:0] ^ cmp_i[BYTE_W-1:0]) & mask) == '0;

  always_comb begin
    unique case (pix_fmt_e'(fmt_i))
      FMT_8:   wide_hit = pix_i[BYTE_W-1:0] == cmp_i[BYTE_W-1:0];
      FMT_16:  wide_hit = pix_i[HI_W-1:0] == cmp_i[HI_W-1:0];
      default: wide_hit = pix_i[CMP_W-1:0] == cmp_i;
    endcase
  end

  always_comb begin
    raw = 1'b0;
    if (cmp_en_i) begin
      if (src_i == SRC_MASKED_OR_B15)     raw = masked_hit;
      else if (src_i == SRC_WIDE_OR_ZERO) raw = wide_hit;
    end else begin
      if (src_i == SRC_MASKED_OR_B15)     raw = pix_i[MID_B];
      else if (src_i == SRC_TOP_BIT)      raw = pix_i[PIX_W-1];
    end
  end

  assign ovl_o = raw ^ inv_i;
endmodule

// File: rtl/blend_factor_gen.sv
module blend_factor_gen #(
  parameter int COEF_W    = 8,
  parameter int GAIN_W    = 2,
  parameter int MAX_SHIFT = 2
) (
  input  logic              dyn_i,
  input  logic              ovl_i,
  input  logic [COEF_W-1:0] lvl_on_i,
  input  logic [COEF_W-1:0] lvl_off_i,
  input  logic [COEF_W-1:0] live_i,
  input  logic [COEF_W-1:0] zero_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic              inv_i,
  output logic [COEF_W-1:0] coef_o
);
  localparam int EXT_W = COEF_W + MAX_SHIFT;

  logic [COEF_W:0]     diff;
  logic [GAIN_W-1:0]   shamt;
  logic [EXT_W-1:0]    shifted;
  logic [COEF_W-1:0]   dyn;
  logic [COEF_W-1:0]   raw;

  assign diff  = {1'b0, live_i} - {1'b0, zero_i};
  assign shamt = (int'(gain_i) > MAX_SHIFT) ? GAIN_W'(MAX_SHIFT) : gain_i;

  always_comb begin
    shifted = {{MAX_SHIFT{1'b0}}, diff[COEF_W-1:0]} << shamt;
    if (diff[COEF_W])                   dyn = '0;   // borrow: clamp low
    else if (|shifted[EXT_W-1:COEF_W])  dyn = '1;   // overflow: clamp high
    else                                dyn = shifted[COEF_W-1:0];
  end

  assign raw    = dyn_i ? dyn : (ovl_i ? lvl_on_i : lvl_off_i);
  assign coef_o = raw ^ {COEF_W{inv_i}};
endmodule

// File: rtl/ovl_blend_gen.sv
module ovl_blend_gen #(
  parameter int PIX_W  = 32,
  parameter int CMP_W  = 24,
  parameter int COEF_W = 8,
  parameter int GAIN_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pix_valid_i,
  input  logic [PIX_W-1:0]  pix_data_i,
  input  logic [COEF_W-1:0] live_mix_i,
  input  logic              cmp_en_i,
  input  logic [1:0]        ovl_src_i,
  input  logic [1:0]        pix_fmt_i,
  input  logic [CMP_W-1:0]  cmp_value_i,
  input  logic              ovl_inv_i,
  input  logic              blend_mode_i,
  input  logic [COEF_W-1:0] lvl_on_i,
  input  logic [COEF_W-1:0] lvl_off_i,
  input  logic [COEF_W-1:0] mix_zero_i,
  input  logic [GAIN_W-1:0] mix_gain_i,
  input  logic              mix_inv_i,
  output logic              valid_o,
  output logic              ovl_o,
  output logic [COEF_W-1:0] blend_o
);
  logic              ovl_d;
  logic [COEF_W-1:0] coef_d;

  ovl_key_sel #(.PIX_W(PIX_W), .CMP_W(CMP_W)) u_key (
    .pix_i    (pix_data_i),
    .cmp_en_i (cmp_en_i),
    .src_i    (ovl_src_i),
    .fmt_i    (pix_fmt_i),
    .cmp_i    (cmp_value_i),
    .inv_i    (ovl_inv_i),
    .ovl_o    (ovl_d)
  );

  blend_factor_gen #(.COEF_W(COEF_W), .GAIN_W(GAIN_W), .MAX_SHIFT(2)) u_coef (
    .dyn_i     (blend_mode_i),
    .ovl_i     (ovl_d),
    .lvl_on_i  (lvl_on_i),
    .lvl_off_i (lvl_off_i),
    .live_i    (live_mix_i),
    .zero_i    (mix_zero_i),
    .gain_i    (mix_gain_i),
    .inv_i     (mix_inv_i),
    .coef_o    (coef_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      ovl_o   <= 1'b0;
      blend_o <= '0;
    end else begin
      valid_o <= pix_valid_i;
      if (pix_valid_i) begin
        ovl_o   <= ovl_d;
        blend_o <= coef_d;
      end
    end
  end
endmodule

// File: rtl/ovl_blend_gen_chk.sv
module ovl_blend_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pix_valid_i,
  input logic       pix_b15_i,
  input logic       cmp_en_i,
  input logic [1:0] ovl_src_i,
  input logic       ovl_inv_i,
  input logic       blend_mode_i,
  input logic [7:0] lvl_on_i,
  input logic [7:0] lvl_off_i,
  input logic [7:0] live_mix_i,
  input logic [7:0] mix_zero_i,
  input logic       mix_inv_i,
  input logic       valid_o,
  input logic       ovl_o,
  input logic [7:0] blend_o
);
  always_comb begin
    if (!rst_ni) begin
      a_r1_reset_clear: assert (!valid_o && !ovl_o && blend_o == 8'd0);
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> valid_o == $past(pix_valid_i));

  a_r2_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_i |=> $stable(ovl_o) && $stable(blend_o));

  a_r5_bit15_path: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_i && !cmp_en_i && ovl_src_i == 2'd0
      |=> ovl_o == ($past(pix_b15_i) ^ $past(ovl_inv_i)));

  a_r5_const_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_i && !cmp_en_i && ovl_src_i == 2'd2 && !ovl_inv_i |=> !ovl_o);

  a_r7_bilevel_pick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_i && !blend_mode_i && !mix_inv_i
      |=> blend_o == (ovl_o ? $past(lvl_on_i) : $past(lvl_off_i)));

  a_r9_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_i && blend_mode_i && !mix_inv_i && live_mix_i <= mix_zero_i
      |=> blend_o == 8'd0);
endmodule

bind ovl_blend_gen ovl_blend_gen_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pix_valid_i  (pix_valid_i),
  .pix_b15_i    (pix_data_i[15]),
  .cmp_en_i     (cmp_en_i),
  .ovl_src_i    (ovl_src_i),
  .ovl_inv_i    (ovl_inv_i),
  .blend_mode_i (blend_mode_i),
  .lvl_on_i     (lvl_on_i),
  .lvl_off_i    (lvl_off_i),
  .live_mix_i   (live_mix_i),
  .mix_zero_i   (mix_zero_i),
  .mix_inv_i    (mix_inv_i),
  .valid_o      (valid_o),
  .ovl_o        (ovl_o),
  .blend_o      (blend_o)
);

// File: tb/ovl_blend_gen_test.sv
module ovl_blend_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pv = 1'b0;
  logic [31:0] pix = '0;
  logic [7:0]  live = '0;
  logic        cen = 1'b0;
  logic [1:0]  src = '0;
  logic [1:0]  fmt = '0;
  logic [23:0] cmpv = '0;
  logic        oinv = 1'b0;
  logic        bmode = 1'b0;
  logic [7:0]  lon = '0, loff = '0, zero = '0;
  logic [1:0]  gain = '0;
  logic        minv = 1'b0;
  logic        valid_o, ovl_o;
  logic [7:0]  blend_o;

  int checks = 0;
  int fails  = 0;
  bit exp_ovl_q = 1'b0;
  logic [7:0] exp_bl_q = '0;

  always #2 clk = ~clk;

  ovl_blend_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .pix_valid_i(pv), .pix_data_i(pix),
    .live_mix_i(live), .cmp_en_i(cen), .ovl_src_i(src), .pix_fmt_i(fmt),
    .cmp_value_i(cmpv), .ovl_inv_i(oinv), .blend_mode_i(bmode),
    .lvl_on_i(lon), .lvl_off_i(loff), .mix_zero_i(zero), .mix_gain_i(gain),
    .mix_inv_i(minv), .valid_o(valid_o), .ovl_o(ovl_o), .blend_o(blend_o)
  );

  function automatic bit model_ovl();
    bit raw = 1'b0;
    bit [7:0] m = cmpv[23:16];
    if (cen) begin
      if (src == 2'd0) raw = ((pix[7:0] & m) == (cmpv[7:0] & m));      // R3
      else if (src == 2'd2) begin                                       // R4
        case (fmt)
          2'd0:    raw = pix[7:0] == cmpv[7:0];
          2'd1:    raw = pix[14:0] == cmpv[14:0];
          default: raw = pix[23:0] == cmpv[23:0];
        endcase
      end
    end else begin                                                      // R5
      if (src == 2'd0) raw = pix[15];
      else if (src == 2'd1) raw = pix[31];
    end
    return raw ^ oinv;                                                  // R6
  endfunction

  function automatic logic [7:0] model_blend(bit ov);
    int v;
    int g = (gain == 2'd3) ? 2 : int'(gain);
    if (bmode) begin                                                    // R8
      v = int'(live) - int'(zero);
      if (v < 0) v = 0;                                                 // R9
      v = v << g;
      if (v > 255) v = 255;
    end else v = ov ? int'(lon) : int'(loff);                           // R7
    return 8'(v) ^ {8{minv}};                                           // R10
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive on negedge, clock once, compare at the following negedge
  task automatic step(string req);
    bit eo;
    logic [7:0] eb;
    bit ev = pv;
    eo = pv ? model_ovl() : exp_ovl_q;
    eb = pv ? model_blend(eo) : exp_bl_q;
    @(posedge clk);
    @(negedge clk);
    exp_ovl_q = eo;
    exp_bl_q  = eb;
    check(valid_o == ev, "R2", {req, " valid"}, int'(valid_o), int'(ev));
    check(ovl_o == eo, req, "ovl", int'(ovl_o), int'(eo));
    check(blend_o == eb, req, "blend", int'(blend_o), int'(eb));
  endtask

  task automatic idle_defaults();
    pv = 1'b1; cen = 1'b0; src = 2'd2; fmt = 2'd0; oinv = 1'b0;
    bmode = 1'b0; minv = 1'b0; gain = 2'd0;
  endtask

  initial begin
    #800000;
    fails++; checks++;
    $display("FAIL watchdog timeout");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check(!valid_o && !ovl_o && blend_o == 8'd0, "R1", "reset outputs",
          int'({valid_o, ovl_o, blend_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: masked compare, middle byte irrelevant
    idle_defaults(); cen = 1'b1; src = 2'd0;
    cmpv = 24'hF0_5A_3C; pix = 32'h0000_0035; step("R3");   // high nibble matches
    cmpv = 24'hF0_A5_3C; step("R3");                        // middle byte changed
    pix = 32'h0000_0045; step("R3");                        // mismatch
    cmpv = 24'h00_00_FF; pix = 32'h0; step("R3");           // empty mask -> hit

    // R4: width boundaries
    cen = 1'b1; src = 2'd2; cmpv = 24'h12_34_56;
    fmt = 2'd0; pix = 32'hFFFF_FF56; step("R4");
    fmt = 2'd1; pix = 32'hFFFF_B456; step("R4");            // bit15 outside key
    pix = 32'hFFFF_3456; cmpv = 24'h12_B4_56; step("R4");   // key bit15 ignored
    fmt = 2'd2; pix = 32'hAB12_3456; cmpv = 24'h12_34_56; step("R4");
    fmt = 2'd3; pix = 32'hAB13_3456; step("R4");

    // R5: fixed bits and constants
    cen = 1'b0; pix = 32'h8000_8000;
    for (int s = 0; s < 4; s++) begin src = 2'(s); step("R5"); end
    cen = 1'b1; src = 2'd1; step("R5");
    src = 2'd3; step("R5");

    // R6: invert
    cen = 1'b0; src = 2'd2; oinv = 1'b1; step("R6");

    // R7: bilevel
    lon = 8'hC3; loff = 8'h1E; oinv = 1'b0; src = 2'd0; pix = 32'h0000_8000; step("R7");
    pix = 32'h0; step("R7");

    // R8/R9: dynamic
    bmode = 1'b1; live = 8'd100; zero = 8'd40;
    for (int g = 0; g < 4; g++) begin gain = 2'(g); step("R8"); end
    live = 8'd40; step("R9");                               // zero difference
    live = 8'd10; step("R9");                               // underflow
    live = 8'd104; gain = 2'd2; step("R9");                 // exactly 256 -> 255
    live = 8'd103; step("R9");                              // 252 no clamp

    // R10: coefficient invert in both modes
    minv = 1'b1; step("R10");
    bmode = 1'b0; step("R10");

    // R2: idle cycles hold outputs despite changed inputs
    pv = 1'b0; lon = 8'h00; loff = 8'hFF; pix = ~pix; step("R2");
    minv = 1'b0; step("R2");
    pv = 1'b1; step("R2");

    // random mix
    for (int i = 0; i < 600; i++) begin
      pv = ($urandom % 8) != 0;
      cen = 1'($urandom); src = 2'($urandom); fmt = 2'($urandom);
      cmpv = 24'($urandom);
      pix = $urandom;
      if ($urandom % 2) pix[23:0] = cmpv ^ (24'h1 << ($urandom % 24)) * 24'($urandom % 2);
      oinv = 1'($urandom); bmode = 1'($urandom); minv = 1'($urandom);
      lon = 8'($urandom); loff = 8'($urandom);
      live = 8'($urandom); zero = 8'($urandom); gain = 2'($urandom);
      step("R3_R10");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule